// File: doc/BRIEF.md
# Delayed-Branch Fetch PC Sequencer

This block produces the fetch program counter for a five-stage, in-order pipeline whose control-flow instructions have one architectural delay slot. Branch and jump decisions are made while the control instruction sits in decode. By that time the next sequential instruction is already being fetched, so the redirect lands on the fetch that follows it. That instruction, the delay slot, is never discarded.

Decode supplies the instruction kind, two forwarded register operands, a 16-bit offset, the decode PC, a stall and an exception request. The block returns the next fetch PC and marks the decode instruction when it is a delay slot. It records an exception return PC together with a flag that says whether the faulting instruction was a slot. In that case the return PC names the branch, so the handler restarts the whole branch/slot pair. A control instruction placed in a slot is reported as an illegal sequence and causes no redirect.

Top module: `dslot_fetch_seq`

## Requirements
- R1: After reset, fetch_pc_o equals RESET_PC (default 0xBFC00000), and id_in_slot_o, exc_in_slot_o, illegal_seq_o and epc_o are all zero.
- R2: On a cycle with no stall and no exception, when decode holds a non-control kind, fetch_pc_o advances by 4 at the next edge. Kind codes 0 and 9 to 15 are non-control.
- R3: Kind codes 1 to 6 are conditional branches, each comparing rs_val_i as a signed 32-bit integer. They are 1 = rs equals rt, 2 = rs differs from rt, 3 = rs < 0, 4 = rs >= 0, 5 = rs <= 0 and 6 = rs > 0. A branch that is not taken advances by 4.
- R4: The target of a taken conditional branch and of kind 7 (jump) is id_pc_i + 4 + (sign-extended offset_i << 2). Kind 8 (jump-register) goes to rs_val_i. Both jumps are always taken.
- R5: The cycle after a control instruction leaves decode, id_in_slot_o is 1 for the instruction now in decode. This is the instruction fetched while the branch was decoded, and it is never squashed. The redirect takes effect only on the fetch after it.
- R6: While stall_i is high and exc_req_i is low, fetch_pc_o and id_in_slot_o hold their values.
- R7: exc_req_i overrides stall and every branch. At the next edge fetch_pc_o becomes EXC_VEC (default 0x80000180), and id_in_slot_o clears.
- R8: An exception taken while id_in_slot_o is 1 sets epc_o to the PC of the preceding branch and sets exc_in_slot_o to 1.
- R9: An exception taken while id_in_slot_o is 0 sets epc_o to id_pc_i and clears exc_in_slot_o.
- R10: A control kind (1 to 8) in decode while id_in_slot_o is 1 drives illegal_seq_o high in the same cycle. That instruction causes no redirect (fetch advances by 4), and the instruction after it is not marked as a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kind_i | input | 4 | Decoded control kind of the decode instruction |
| rs_val_i | input | 32 | Forwarded first register operand |
| rt_val_i | input | 32 | Forwarded second register operand |
| offset_i | input | 16 | Branch offset in words |
| id_pc_i | input | 32 | PC of the decode instruction |
| stall_i | input | 1 | Hold fetch and slot state |
| exc_req_i | input | 1 | Exception raised by the decode instruction |
| fetch_pc_o | output | 32 | Next fetch PC |
| id_in_slot_o | output | 1 | Decode instruction is a delay slot |
| epc_o | output | 32 | Saved exception return PC |
| exc_in_slot_o | output | 1 | Faulting instruction was a delay slot |
| illegal_seq_o | output | 1 | Control instruction found in a delay slot |

## Verification
The assertions place no constraint on operand values. They take kind_i as meaningful only on cycles that advance without an exception, and they treat exc_req_i as applying to the instruction currently in decode. The stimulus drives id_pc_i from the PC the bench last expected to be fetched, so decode follows the real instruction stream. Random kinds are drawn from all sixteen codes. Operands come from a pool rich in zero, ±1 and the signed extremes, so equality and sign boundaries are hit often. A control kind that lands in a slot is usually replaced by a plain instruction, so illegal sequences stay rare but still occur, alongside directed cases.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  typedef enum logic [3:0] {
    K_NONE = 4'd0,
    K_EQ   = 4'd1,
    K_NE   = 4'd2,
    K_LTZ  = 4'd3,
    K_GEZ  = 4'd4,
    K_LEZ  = 4'd5,
    K_GTZ  = 4'd6,
    K_JMP  = 4'd7,
    K_JREG = 4'd8
  } ctl_kind_e;

  function automatic logic is_ctl(input logic [3:0] k);
    return (k >= 4'd1) && (k <= 4'd8);
  endfunction
endpackage

// File: rtl/dslot_cond_eval.sv
module dslot_cond_eval
  import dslot_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      kind_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            take_o
);
  logic rs_neg, rs_zero, ops_eq;

  assign rs_neg  = rs_i[XLEN-1];
  assign rs_zero = (rs_i == '0);
  assign ops_eq  = (rs_i == rt_i);

  always_comb begin
    unique case (ctl_kind_e'(kind_i))
      K_EQ:    take_o = ops_eq;
      K_NE:    take_o = !ops_eq;
      K_LTZ:   take_o = rs_neg;
      K_GEZ:   take_o = !rs_neg;
      K_LEZ:   take_o = rs_neg || rs_zero;
      K_GTZ:   take_o = !rs_neg && !rs_zero;
      K_JMP:   take_o = 1'b1;
      K_JREG:  take_o = 1'b1;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dslot_target_gen.sv
module dslot_target_gen
  import dslot_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16
) (
  input  logic [3:0]       kind_i,
  input  logic [XLEN-1:0]  id_pc_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [XLEN-1:0]  rs_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int EXT_W = XLEN - OFS_W - 2;

  logic [XLEN-1:0] disp, rel_target;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{offset_i[OFS_W-1]}}, offset_i, 2'b00};
    end else begin : g_trunc
      assign disp = {offset_i[XLEN-3:0], 2'b00};
    end
  endgenerate

  assign rel_target = id_pc_i + XLEN'(4) + disp;
  assign target_o   = (ctl_kind_e'(kind_i) == K_JREG) ? rs_i : rel_target;
endmodule

// File: rtl/dslot_slot_track.sv
module dslot_slot_track
  import dslot_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            advance_i,
  input  logic            flush_i,
  input  logic [3:0]      kind_i,
  input  logic [XLEN-1:0] id_pc_i,
  output logic            in_slot_o,
  output logic [XLEN-1:0] br_pc_o,
  output logic            illegal_o,
  output logic            redirect_ok_o
);
  logic ctl;

  assign ctl           = is_ctl(kind_i);
  assign illegal_o     = in_slot_o && ctl;
  assign redirect_ok_o = ctl && !in_slot_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_slot_o <= 1'b0;
      br_pc_o   <= '0;
    end else if (flush_i) begin
      in_slot_o <= 1'b0;
    end else if (advance_i) begin
      in_slot_o <= redirect_ok_o;
      if (redirect_ok_o) br_pc_o <= id_pc_i;
    end
  end
endmodule

// File: rtl/dslot_epc_cap.sv
module dslot_epc_cap #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_i,
  input  logic            in_slot_i,
  input  logic [XLEN-1:0] br_pc_i,
  input  logic [XLEN-1:0] id_pc_i,
  output logic [XLEN-1:0] epc_o,
  output logic            exc_slot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o      <= '0;
      exc_slot_o <= 1'b0;
    end else if (exc_i) begin
      epc_o      <= in_slot_i ? br_pc_i : id_pc_i;
      exc_slot_o <= in_slot_i;
    end
  end
endmodule

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq
  import dslot_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OFS_W    = 16,
  parameter logic [31:0] RESET_PC = 32'hBFC0_0000,
  parameter logic [31:0] EXC_VEC  = 32'h8000_0180
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       kind_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [XLEN-1:0]  id_pc_i,
  input  logic             stall_i,
  input  logic             exc_req_i,
  output logic [XLEN-1:0]  fetch_pc_o,
  output logic             id_in_slot_o,
  output logic [XLEN-1:0]  epc_o,
  output logic             exc_in_slot_o,
  output logic             illegal_seq_o
);
  logic            advance, take, redirect_ok;
  logic [XLEN-1:0] target, br_pc, pc_q, pc_d;

  assign advance = !stall_i && !exc_req_i;

  dslot_cond_eval #(.XLEN(XLEN)) u_cond (
    .kind_i (kind_i),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .take_o (take)
  );

  dslot_target_gen #(.XLEN(XLEN), .OFS_W(OFS_W)) u_tgt (
    .kind_i   (kind_i),
    .id_pc_i  (id_pc_i),
    .offset_i (offset_i),
    .rs_i     (rs_val_i),
    .target_o (target)
  );

  dslot_slot_track #(.XLEN(XLEN)) u_slot (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .advance_i     (advance),
    .flush_i       (exc_req_i),
    .kind_i        (kind_i),
    .id_pc_i       (id_pc_i),
    .in_slot_o     (id_in_slot_o),
    .br_pc_o       (br_pc),
    .illegal_o     (illegal_seq_o),
    .redirect_ok_o (redirect_ok)
  );

  dslot_epc_cap #(.XLEN(XLEN)) u_epc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exc_i      (exc_req_i),
    .in_slot_i  (id_in_slot_o),
    .br_pc_i    (br_pc),
    .id_pc_i    (id_pc_i),
    .epc_o      (epc_o),
    .exc_slot_o (exc_in_slot_o)
  );

  // Slot is already in fetch while the branch decodes; redirect lands after it.
  always_comb begin
    if (exc_req_i)                pc_d = XLEN'(EXC_VEC);
    else if (stall_i)             pc_d = pc_q;
    else if (redirect_ok && take) pc_d = target;
    else                          pc_d = pc_q + XLEN'(4);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= XLEN'(RESET_PC);
    else         pc_q <= pc_d;
  end

  assign fetch_pc_o = pc_q;
endmodule

// File: rtl/dslot_fetch_seq_chk.sv
module dslot_fetch_seq_chk #(
  parameter int          XLEN    = 32,
  parameter logic [31:0] EXC_VEC = 32'h8000_0180
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [3:0]      kind_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic [XLEN-1:0] id_pc_i,
  input logic            stall_i,
  input logic            exc_req_i,
  input logic [XLEN-1:0] fetch_pc_o,
  input logic            id_in_slot_o,
  input logic [XLEN-1:0] epc_o,
  input logic            exc_in_slot_o,
  input logic            illegal_seq_o
);
  logic ctl;
  assign ctl = (kind_i >= 4'd1) && (kind_i <= 4'd8);

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i && !exc_req_i |=> $stable(fetch_pc_o) && $stable(id_in_slot_o));

  // R7
  exc_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> fetch_pc_o == XLEN'(EXC_VEC) && !id_in_slot_o);

  // R9
  exc_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && !id_in_slot_o |=> !exc_in_slot_o && epc_o == $past(id_pc_i));

  // R8
  exc_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && id_in_slot_o |=> exc_in_slot_o);

  // R5
  slot_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl && !id_in_slot_o && !stall_i && !exc_req_i |=> id_in_slot_o);

  // R10
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_seq_o == (ctl && id_in_slot_o));

  // R10
  illegal_noredir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_seq_o && !stall_i && !exc_req_i |=>
      !id_in_slot_o && fetch_pc_o == $past(fetch_pc_o) + XLEN'(4));

  // R4
  jreg_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == 4'd8 && !id_in_slot_o && !stall_i && !exc_req_i |=>
      fetch_pc_o == $past(rs_val_i));

  // R2
  seq_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl && !stall_i && !exc_req_i |=> fetch_pc_o == $past(fetch_pc_o) + XLEN'(4));
endmodule

bind dslot_fetch_seq dslot_fetch_seq_chk #(.XLEN(XLEN), .EXC_VEC(EXC_VEC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .kind_i        (kind_i),
  .rs_val_i      (rs_val_i),
  .id_pc_i       (id_pc_i),
  .stall_i       (stall_i),
  .exc_req_i     (exc_req_i),
  .fetch_pc_o    (fetch_pc_o),
  .id_in_slot_o  (id_in_slot_o),
  .epc_o         (epc_o),
  .exc_in_slot_o (exc_in_slot_o),
  .illegal_seq_o (illegal_seq_o)
);

// File: tb/dslot_fetch_seq_test.sv
module dslot_fetch_seq_test;
  localparam logic [31:0] RST_PC = 32'hBFC0_0000;
  localparam logic [31:0] VEC    = 32'h8000_0180;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0]  kind_i = '0;
  logic [31:0] rs_val_i = '0, rt_val_i = '0, id_pc_i = '0;
  logic [15:0] offset_i = '0;
  logic        stall_i = 1'b0, exc_req_i = 1'b0;
  logic [31:0] fetch_pc_o, epc_o;
  logic        id_in_slot_o, exc_in_slot_o, illegal_seq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_fpc, m_id_pc, m_brpc, m_epc;
  logic        m_slot, m_eslot;

  always #2 clk_i = ~clk_i;

  dslot_fetch_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .kind_i(kind_i), .rs_val_i(rs_val_i),
    .rt_val_i(rt_val_i), .offset_i(offset_i), .id_pc_i(id_pc_i),
    .stall_i(stall_i), .exc_req_i(exc_req_i), .fetch_pc_o(fetch_pc_o),
    .id_in_slot_o(id_in_slot_o), .epc_o(epc_o), .exc_in_slot_o(exc_in_slot_o),
    .illegal_seq_o(illegal_seq_o)
  );

  function automatic bit f_ctl(input logic [3:0] k);
    return k >= 4'd1 && k <= 4'd8;
  endfunction

  function automatic bit f_take(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) < 0;
      4'd4: return $signed(a) >= 0;
      4'd5: return $signed(a) <= 0;
      4'd6: return $signed(a) > 0;
      4'd7, 4'd8: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] f_target(input logic [3:0] k, input logic [31:0] pc,
                                           input logic [15:0] ofs, input logic [31:0] a);
    if (k == 4'd8) return a;
    return pc + 32'd4 + {{14{ofs[15]}}, ofs, 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; leaves at the next negedge with outputs checked.
  task automatic step(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] ofs, input bit st, input bit ex);
    bit ctl, ill, tk;
    string tag, etag;
    kind_i = k; rs_val_i = a; rt_val_i = b; offset_i = ofs;
    stall_i = st; exc_req_i = ex; id_pc_i = m_id_pc;
    ctl = f_ctl(k);
    ill = m_slot && ctl;
    tk = f_take(k, a, b);
    #1;
    chk("R5 slot flag", {31'd0, id_in_slot_o}, {31'd0, m_slot});
    chk("R10 illegal flag", {31'd0, illegal_seq_o}, {31'd0, ill});
    if (ex) tag = "R7";
    else if (st) tag = "R6";
    else if (ill) tag = "R10";
    else if (k >= 4'd1 && k <= 4'd6) tag = "R3";
    else if (ctl) tag = "R4";
    else tag = "R2";
    etag = m_slot ? "R8" : "R9";
    @(posedge clk_i);
    if (ex) begin
      m_epc = m_slot ? m_brpc : m_id_pc;
      m_eslot = m_slot;
      m_slot = 0;
      m_id_pc = m_fpc;
      m_fpc = VEC;
    end else if (!st) begin
      m_slot = ctl && !ill;
      if (m_slot) m_brpc = m_id_pc;
      m_id_pc = m_fpc;
      m_fpc = (ctl && !ill && tk) ? f_target(k, id_pc_i, ofs, a) : m_fpc + 32'd4;
    end
    @(negedge clk_i);
    chk({tag, " fetch pc"}, fetch_pc_o, m_fpc);
    chk({tag, " next slot flag"}, {31'd0, id_in_slot_o}, {31'd0, m_slot});
    if (ex) begin
      chk({etag, " epc"}, epc_o, m_epc);
      chk({etag, " exc slot bit"}, {31'd0, exc_in_slot_o}, {31'd0, m_eslot});
    end
  endtask

  function automatic logic [31:0] pick_op();
    case ($urandom % 7)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'd5;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_fpc = RST_PC; m_id_pc = 32'h0; m_brpc = 0; m_epc = 0; m_slot = 0; m_eslot = 0;
    #9;
    // R1 reset state
    chk("R1 fetch pc", fetch_pc_o, RST_PC);
    chk("R1 flags", {29'd0, id_in_slot_o, exc_in_slot_o, illegal_seq_o}, 32'd0);
    chk("R1 epc", epc_o, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 each condition, taken then not taken, each followed by a slot
    step(4'd1, 32'd7, 32'd7, 16'd3, 0, 0);           step(0, 0, 0, 0, 0, 0);
    step(4'd1, 32'd7, 32'd8, 16'd3, 0, 0);           step(0, 0, 0, 0, 0, 0);
    step(4'd2, 32'd7, 32'd8, 16'hFFFC, 0, 0);        step(0, 0, 0, 0, 0, 0);
    step(4'd2, 32'd9, 32'd9, 16'hFFFC, 0, 0);        step(0, 0, 0, 0, 0, 0);
    step(4'd3, 32'h8000_0000, 0, 16'd10, 0, 0);      step(0, 0, 0, 0, 0, 0);
    step(4'd3, 32'd0, 0, 16'd10, 0, 0);              step(0, 0, 0, 0, 0, 0);
    step(4'd4, 32'd0, 0, 16'd2, 0, 0);               step(0, 0, 0, 0, 0, 0);
    step(4'd4, 32'hFFFF_FFFF, 0, 16'd2, 0, 0);       step(0, 0, 0, 0, 0, 0);
    step(4'd5, 32'd0, 0, 16'd6, 0, 0);               step(0, 0, 0, 0, 0, 0);
    step(4'd5, 32'd1, 0, 16'd6, 0, 0);               step(0, 0, 0, 0, 0, 0);
    step(4'd6, 32'h7FFF_FFFF, 0, 16'd1, 0, 0);       step(0, 0, 0, 0, 0, 0);
    step(4'd6, 32'd0, 0, 16'd1, 0, 0);               step(0, 0, 0, 0, 0, 0);
    // R4 jumps
    step(4'd7, 0, 0, 16'h8000, 0, 0);                step(0, 0, 0, 0, 0, 0);
    step(4'd8, 32'h0000_4000, 0, 0, 0, 0);           step(0, 0, 0, 0, 0, 0);
    // R6 stall while the slot is in decode
    step(4'd1, 32'd3, 32'd3, 16'd8, 0, 0);
    step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 0);
    // R8 exception on a slot instruction
    step(4'd2, 32'd1, 32'd2, 16'd4, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    // R7 exception overrides a stall, R9 exception on a plain instruction
    step(0, 0, 0, 0, 0, 0);
    step(4'd7, 0, 0, 16'd5, 1, 1);
    // R10 branch inside a slot
    step(4'd7, 0, 0, 16'd20, 0, 0);
    step(4'd8, 32'h1234_0000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] k;
      k = 4'($urandom % 16);
      if (m_slot && f_ctl(k) && ($urandom % 8 != 0)) k = 0;
      step(k, pick_op(), pick_op(), 16'($urandom), ($urandom % 7) == 0, ($urandom % 19) == 0);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule